// File: doc/BRIEF.md
# Prescaled Baud Rate Tick Generator

This block turns a fixed system clock into the timing pulses a UART needs: one single-cycle pulse per bit period, plus a second pulse halfway through each bit. The second pulse lets a transmitter end a one-and-a-half stop bit, and lets a receiver sample at mid-bit. Software computes a 16-bit divider and a prescale select. The bit period is then 2 × prescale × divider system clocks, where prescale is 4 when the select is set and 1 otherwise. At a 24 MHz clock, a divider of 12 with prescale 1 gives 1 Mbaud. The slowest rates use prescale 4.

Counting starts again cleanly each time `en` rises. The configuration inputs are captured only at a bit boundary, so a rate change never produces a short or stretched bit. Two settings are rejected and raise `cfg_err`, and no pulses are produced while either is held:
- a zero divider;
- a 5- or 6-bit frame that asks for more than 500 kbaud, which is a half period below 24 system clocks.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, and until `en` is sampled high, `bit_tick`, `half_tick` and `cfg_err` are all low.
- R2: With a valid setting held, consecutive `bit_tick` pulses are exactly 2 × P × `divider` clocks apart, and each pulse lasts one cycle.
- R3: P is 4 when `pre4_sel` is 1 and P is 1 when `pre4_sel` is 0.
- R4: The first `bit_tick` after `en` is sampled high appears in the cycle that ends one full period (2 × P × `divider` clocks) after that sampling edge.
- R5: `half_tick` pulses for one cycle P × `divider` clocks after the start of each bit period, which is midway through the bit.
- R6: A `divider` of 0 is invalid: `cfg_err` is high and neither tick fires while it is the active setting.
- R7: When `narrow_frame` is 1 (a 5- or 6-bit frame) and P × `divider` is below 24, the setting is invalid and behaves as in R6. A value of exactly 24 is valid.
- R8: A change to `divider`, `pre4_sel` or `narrow_frame` during a bit period does not alter that period. The new setting is captured at the clock edge that ends the period, and it governs the next period.
- R9: A low `en` sampled at a clock edge leaves both ticks and `cfg_err` low in the following cycle.
- R10: `bit_tick` and `half_tick` are never high in the same cycle. This includes the shortest period of 2 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable; a rising level restarts the period count |
| divider | input | 16 | Clock divider computed by software |
| pre4_sel | input | 1 | 1 selects prescale 4, 0 selects prescale 1 |
| narrow_frame | input | 1 | 1 when the frame carries 5 or 6 data bits |
| bit_tick | output | 1 | One-cycle pulse at the end of each bit period |
| half_tick | output | 1 | One-cycle pulse at the middle of each bit period |
| cfg_err | output | 1 | Active setting is invalid; ticks are suppressed |

## Verification
The generator is driven with several kinds of setting:
- The smallest period (divider 1), a mid-range divider and the 1 Mbaud divider of 12. These separate period arithmetic from off-by-one errors in the reload.
- Prescale-4 settings. These show that the prescale multiplies both pulses and not only the bit pulse.
- A divider change in the middle of a bit. This tells apart capture at the boundary from immediate use.
- Narrow frames on each side of the 24-clock half-period limit, under both prescales, plus a zero divider. These pin the exact comparison used by the rejection check.

A behavioural model follows the same stimulus and is compared with all three outputs on every clock.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

    typedef enum logic {
        PRE_X1 = 1'b0,
        PRE_X4 = 1'b1
    } prescale_e;

    // Left shift that applies the prescale to a divider (x1 or x4).
    function automatic int unsigned prescale_shift(prescale_e sel);
        return (sel == PRE_X4) ? 2 : 0;
    endfunction

endpackage

// File: rtl/baud_cfg_decode.sv
module baud_cfg_decode
    import baud_tick_pkg::*;
#(
    parameter int DIV_W = 16,
    parameter int CNT_W = DIV_W + 3,
    parameter int MIN_HALF = 24
) (
    input  logic [DIV_W-1:0] div,
    input  logic             pre4,
    input  logic             narrow,
    output logic [CNT_W-1:0] half_len,
    output logic [CNT_W-1:0] full_len,
    output logic             valid
);
    localparam logic [CNT_W-1:0] MIN_HALF_L = CNT_W'(MIN_HALF);

    logic [CNT_W-1:0] div_ext;
    logic             too_fast;

    always_comb begin
        div_ext  = CNT_W'(div);
        half_len = div_ext << prescale_shift(prescale_e'(pre4));
        full_len = half_len << 1;
        too_fast = narrow && (half_len < MIN_HALF_L);
        valid    = (div != '0) && !too_fast;
    end
endmodule

// File: rtl/baud_tick_detect.sv
module baud_tick_detect #(
    parameter int CNT_W = 19
) (
    input  logic             active,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] half_len,
    input  logic [CNT_W-1:0] full_len,
    output logic             half_hit,
    output logic             full_hit
);
    always_comb begin
        half_hit = active && (cnt == half_len - CNT_W'(1));
        full_hit = active && (cnt == full_len - CNT_W'(1));
    end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int SYS_CLK_HZ      = 24_000_000,
    parameter int NARROW_MAX_BAUD = 500_000,
    parameter int DIV_W           = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] divider,
    input  logic             pre4_sel,
    input  logic             narrow_frame,
    output logic             bit_tick,
    output logic             half_tick,
    output logic             cfg_err
);
    localparam int CNT_W    = DIV_W + 3;
    localparam int MIN_HALF = SYS_CLK_HZ / (2 * NARROW_MAX_BAUD);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [DIV_W-1:0] div;
        logic             pre4;
        logic             narrow;
    } state_t;

    state_t s_d, s_q;

    logic [CNT_W-1:0] half_len, full_len;
    logic             valid, half_hit, full_hit;

    baud_cfg_decode #(
        .DIV_W   (DIV_W),
        .CNT_W   (CNT_W),
        .MIN_HALF(MIN_HALF)
    ) u_decode (
        .div     (s_q.div),
        .pre4    (s_q.pre4),
        .narrow  (s_q.narrow),
        .half_len(half_len),
        .full_len(full_len),
        .valid   (valid)
    );

    baud_tick_detect #(
        .CNT_W(CNT_W)
    ) u_detect (
        .active  (s_q.run && valid),
        .cnt     (s_q.cnt),
        .half_len(half_len),
        .full_len(full_len),
        .half_hit(half_hit),
        .full_hit(full_hit)
    );

    always_comb begin
        s_d = s_q;
        if (!en) begin
            s_d.run    = 1'b0;
            s_d.cnt    = '0;
            s_d.div    = divider;
            s_d.pre4   = pre4_sel;
            s_d.narrow = narrow_frame;
        end else if (!s_q.run || !valid || full_hit) begin
            // Start, retry an invalid setting, or cross a bit boundary.
            s_d.run    = 1'b1;
            s_d.cnt    = '0;
            s_d.div    = divider;
            s_d.pre4   = pre4_sel;
            s_d.narrow = narrow_frame;
        end else begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bit_tick  = full_hit;
    assign half_tick = half_hit;
    assign cfg_err   = s_q.run && !valid;
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic bit_tick,
    input logic half_tick,
    input logic cfg_err
);
    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_tick && half_tick));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!bit_tick && !half_tick && !cfg_err));

    p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!bit_tick && !half_tick));

    p_bit_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    p_half_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |=> !half_tick);

    p_err_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> $past(en));
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .bit_tick (bit_tick),
    .half_tick(half_tick),
    .cfg_err  (cfg_err)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [15:0] divider = '0;
    logic        pre4_sel = 1'b0;
    logic        narrow_frame = 1'b0;
    logic        bit_tick, half_tick, cfg_err;

    always #10 clk = ~clk;

    baud_tick_gen u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .divider     (divider),
        .pre4_sel    (pre4_sel),
        .narrow_frame(narrow_frame),
        .bit_tick    (bit_tick),
        .half_tick   (half_tick),
        .cfg_err     (cfg_err)
    );

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string cur_req = "R1";

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: elapsed clocks in the current bit, active setting.
    int m_run, m_elapsed, m_div, m_pre, m_narrow;

    function automatic int m_period();
        return 2 * m_pre * m_div;
    endfunction

    function automatic bit m_ok();
        return (m_div != 0) && !(m_narrow != 0 && m_pre * m_div < 24);
    endfunction

    function automatic bit m_bit();
        return m_run != 0 && m_ok() && (m_elapsed + 1 == m_period());
    endfunction

    function automatic bit m_half();
        return m_run != 0 && m_ok() && (2 * (m_elapsed + 1) == m_period());
    endfunction

    task automatic m_capture();
        m_div     = divider;
        m_pre     = pre4_sel ? 4 : 1;
        m_narrow  = narrow_frame;
        m_elapsed = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_elapsed = 0; m_div = 0; m_pre = 1; m_narrow = 0;
        end else if (!en) begin
            m_run = 0;
            m_capture();
        end else if (m_run == 0 || !m_ok() || m_bit()) begin
            m_run = 1;
            m_capture();
        end else begin
            m_elapsed++;
        end
    end

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            chk(cur_req, "bit_tick", int'(bit_tick), int'(m_bit()));
            chk(cur_req, "half_tick", int'(half_tick), int'(m_half()));
            chk(cur_req, "cfg_err", int'(cfg_err),
                int'(m_run != 0 && !m_ok()));
        end
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual %0d expected 0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic setcfg(int d, bit p4, bit nar);
        divider      = 16'(d);
        pre4_sel     = p4;
        narrow_frame = nar;
    endtask

    // Clocks between two consecutive bit ticks.
    task automatic measure(output int n);
        n = 0;
        do @(negedge clk); while (!bit_tick && cyc < 140000);
        do begin
            @(negedge clk);
            n++;
        end while (!bit_tick && n < 100000);
    endtask

    task automatic count_until_bit(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!bit_tick && n < 100000);
    endtask

    task automatic window(int cycles, output int nb, output int nh);
        nb = 0; nh = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            nb += int'(bit_tick);
            nh += int'(half_tick);
        end
    endtask

    initial begin
        int n, nb, nh;
        repeat (3) @(negedge clk);
        chk("R1", "reset bit_tick", int'(bit_tick), 0);
        chk("R1", "reset half_tick", int'(half_tick), 0);
        chk("R1", "reset cfg_err", int'(cfg_err), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "idle cfg_err", int'(cfg_err), 0);

        // R4: first tick one full period after enable
        cur_req = "R4";
        setcfg(3, 1'b0, 1'b0);
        en = 1'b1;
        count_until_bit(n);
        chk("R4", "clocks to first tick", n, 6);

        // R2: periods, including 1 Mbaud divider
        cur_req = "R2";
        measure(n);
        chk("R2", "period div3", n, 6);
        setcfg(12, 1'b0, 1'b0);
        measure(n);
        chk("R2", "period div12", n, 24);

        // R8: mid-period change waits for the boundary
        cur_req = "R8";
        @(negedge clk);
        setcfg(5, 1'b0, 1'b0);
        count_until_bit(n);
        chk("R8", "old period kept", n, 23);
        count_until_bit(n);
        chk("R8", "new period", n, 10);

        // R3: prescale 4
        cur_req = "R3";
        setcfg(2, 1'b1, 1'b0);
        measure(n);
        measure(n);
        chk("R3", "period pre4 div2", n, 16);

        // R5: half tick at mid-bit
        cur_req = "R5";
        setcfg(7, 1'b0, 1'b0);
        measure(n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!half_tick && n < 1000);
        chk("R5", "clocks to half tick", n, 7);
        window(56, nb, nh);
        chk("R5", "half ticks in 4 bits", nh, 4);

        // R10: shortest period
        cur_req = "R10";
        setcfg(1, 1'b0, 1'b0);
        measure(n);
        chk("R10", "period div1", n, 2);
        window(20, nb, nh);
        chk("R10", "bit ticks", nb, 10);
        chk("R10", "half ticks", nh, 10);

        // R6: zero divider
        cur_req = "R6";
        setcfg(0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        window(40, nb, nh);
        chk("R6", "ticks with div0", nb + nh, 0);
        chk("R6", "cfg_err div0", int'(cfg_err), 1);

        // R7: narrow frame rate limit
        cur_req = "R7";
        setcfg(23, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        chk("R7", "cfg_err div23 narrow", int'(cfg_err), 1);
        setcfg(24, 1'b0, 1'b1);
        measure(n);
        chk("R7", "period div24 narrow", n, 48);
        chk("R7", "cfg_err div24 narrow", int'(cfg_err), 0);
        setcfg(5, 1'b1, 1'b1);
        repeat (60) @(negedge clk);
        chk("R7", "cfg_err pre4 div5 narrow", int'(cfg_err), 1);
        setcfg(6, 1'b1, 1'b1);
        measure(n);
        chk("R7", "period pre4 div6 narrow", n, 48);
        setcfg(5, 1'b1, 1'b0);
        measure(n);
        measure(n);
        chk("R7", "period pre4 div5 wide", n, 40);

        // R9: disable
        cur_req = "R9";
        en = 1'b0;
        window(60, nb, nh);
        chk("R9", "ticks while disabled", nb + nh, 0);
        chk("R9", "cfg_err while disabled", int'(cfg_err), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule